// File: doc/BRIEF.md
# Floating-Point Escape Prefix Scanner

The scanner looks at an instruction byte stream ahead of a floating-point escape instruction, one byte for each beat on which the valid strobe is high. A start pulse arms it and clears everything it has collected. While it is armed, it accumulates three kinds of override: the address-size override, the operand-size override, and a segment override. Repeat prefixes are consumed and have no other effect. The scan ends when a wait opcode or an escape opcode arrives. Any other byte also ends the scan, but as an error, and this includes the bus-lock prefix.

When the scan ends, the block raises a single-cycle done pulse. It also reports the terminating byte, an error flag and the number of bytes consumed. These results, together with the override fields, hold until the next start pulse, so the decoder that follows can read them at leisure. A length limit bounds the scan. If the limit is reached without a terminator, the scan ends in error.

Top module: `fpesc_prefix_scan`

## Requirements
- R1: On a start pulse, the block clears both override flags, sets the segment code to 0 (no override), sets the count to 0 and clears the error flag, with all of this visible one cycle later. Bytes that are valid while no scan is armed, or in the same cycle as a start pulse, are ignored.
- R2: Byte 0x67 sets the address-size override flag, and the scan continues.
- R3: Byte 0x66 sets the operand-size override flag, and the scan continues.
- R4: Segment prefix bytes write a 3-bit segment code: 0x26 gives 1, 0x2E gives 2, 0x36 gives 3, 0x3E gives 4, 0x64 gives 5 and 0x65 gives 6. A later segment prefix replaces an earlier one.
- R5: Bytes 0xF3 and 0xF2 are counted but change no override, and the scan continues.
- R6: Byte 0x9B ends the scan without error. The done pulse appears in the cycle after the byte is accepted, and the byte is reported as the terminating byte.
- R7: Any byte 0xD8 to 0xDF (top five bits 11011) ends the scan without error, and the byte is reported as the terminating byte.
- R8: Any other byte, including 0xF0, ends the scan with the error flag set, and the byte is reported as the terminating byte.
- R9: The count includes the terminating byte and never exceeds MAX_LEN (default 15). A terminator that arrives as byte MAX_LEN succeeds. A non-terminating byte that arrives as byte MAX_LEN ends the scan with an error.
- R10: After a scan ends, further valid bytes change nothing until the next start pulse.
- R11: The done signal is high for exactly one cycle per scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a new scan and clears the collected state |
| byte_valid_i | input | 1 | The byte on byte_i is valid this cycle |
| byte_i | input | 8 | Stream byte |
| done_o | output | 1 | One-cycle pulse when the scan ends |
| err_o | output | 1 | The last scan ended on an illegal byte or at the length limit |
| term_byte_o | output | 8 | Byte that ended the scan |
| addr_ovr_o | output | 1 | Address-size override seen |
| opnd_ovr_o | output | 1 | Operand-size override seen |
| seg_o | output | 3 | Segment override code, 0 for none |
| count_o | output | 4 | Bytes consumed, including the terminator |

## Verification
The main function is driven with a range of sequences:
- a lone escape byte, and each prefix kind followed by an escape or a wait opcode, which separate the two success paths;
- chains of several segment prefixes, which show that the last one wins;
- repeat prefixes alone, which must leave every override clear;
- the lock byte and unrelated bytes after valid prefixes, which show the error path keeps the overrides collected so far;
- bytes 0xD7 and 0xE0, one either side of the escape range, which catch a wrong mask.

Directed cases cover the following:
- a byte offered together with a start pulse;
- a restart in the middle of a scan;
- bytes offered after a scan has ended;
- a terminator as byte fifteen against a repeat prefix as byte fifteen.

// File: rtl/fpesc_pkg.sv
package fpesc_pkg;

    // Prefix and opcode byte values recognised by the scanner
    localparam logic [7:0] PFX_ADDR  = 8'h67;
    localparam logic [7:0] PFX_OPND  = 8'h66;
    localparam logic [7:0] PFX_ES    = 8'h26;
    localparam logic [7:0] PFX_CS    = 8'h2E;
    localparam logic [7:0] PFX_SS    = 8'h36;
    localparam logic [7:0] PFX_DS    = 8'h3E;
    localparam logic [7:0] PFX_FS    = 8'h64;
    localparam logic [7:0] PFX_GS    = 8'h65;
    localparam logic [7:0] PFX_REPE  = 8'hF3;
    localparam logic [7:0] PFX_REPNE = 8'hF2;
    localparam logic [7:0] OP_WAIT   = 8'h9B;
    localparam logic [4:0] ESC_TOP   = 5'b11011;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0,
        SEG_ES   = 3'd1,
        SEG_CS   = 3'd2,
        SEG_SS   = 3'd3,
        SEG_DS   = 3'd4,
        SEG_FS   = 3'd5,
        SEG_GS   = 3'd6
    } seg_e;

    typedef enum logic [2:0] {
        K_ADDR,
        K_OPND,
        K_SEG,
        K_SKIP,
        K_WAIT,
        K_ESC,
        K_BAD
    } kind_e;

endpackage

// File: rtl/fpesc_byte_class.sv
module fpesc_byte_class
    import fpesc_pkg::*;
(
    input  logic [7:0] byte_in,
    output kind_e      kind,
    output seg_e       seg
);

    always_comb begin
        kind = K_BAD;
        seg  = SEG_NONE;
        if (byte_in[7:3] == ESC_TOP) begin
            kind = K_ESC;
        end else begin
            case (byte_in)
                PFX_ADDR:             kind = K_ADDR;
                PFX_OPND:             kind = K_OPND;
                PFX_ES:    begin kind = K_SEG; seg = SEG_ES; end
                PFX_CS:    begin kind = K_SEG; seg = SEG_CS; end
                PFX_SS:    begin kind = K_SEG; seg = SEG_SS; end
                PFX_DS:    begin kind = K_SEG; seg = SEG_DS; end
                PFX_FS:    begin kind = K_SEG; seg = SEG_FS; end
                PFX_GS:    begin kind = K_SEG; seg = SEG_GS; end
                PFX_REPE,
                PFX_REPNE:            kind = K_SKIP;
                OP_WAIT:              kind = K_WAIT;
                default:              kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/fpesc_len_ctr.sv
module fpesc_len_ctr #(
    parameter int MAX_LEN = 15,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic             at_limit
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LEN);

    always_comb begin
        cnt_next = (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;
        at_limit = (cnt_next == LIMIT);
    end

endmodule

// File: rtl/fpesc_prefix_scan.sv
module fpesc_prefix_scan
    import fpesc_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_i,
    output logic             done_o,
    output logic             err_o,
    output logic [7:0]       term_byte_o,
    output logic             addr_ovr_o,
    output logic             opnd_ovr_o,
    output logic [2:0]       seg_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic             scan;
        logic             done;
        logic             err;
        logic [7:0]       term;
        logic             addr;
        logic             opnd;
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t d, q;

    kind_e            kind;
    seg_e             seg_code;
    logic [CNT_W-1:0] cnt_next;
    logic             at_limit;
    logic             scanning;

    fpesc_byte_class u_class (
        .byte_in (byte_i),
        .kind    (kind),
        .seg     (seg_code)
    );

    fpesc_len_ctr #(
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_len (
        .cnt_q    (q.cnt),
        .cnt_next (cnt_next),
        .at_limit (at_limit)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_i) begin
            d.scan = 1'b1;
            d.err  = 1'b0;
            d.term = '0;
            d.addr = 1'b0;
            d.opnd = 1'b0;
            d.seg  = SEG_NONE;
            d.cnt  = '0;
        end else if (q.scan && byte_valid_i) begin
            d.cnt = cnt_next;
            case (kind)
                K_ADDR: d.addr = 1'b1;
                K_OPND: d.opnd = 1'b1;
                K_SEG:  d.seg  = seg_code;
                default: ;
            endcase
            if (kind == K_WAIT || kind == K_ESC) begin
                d.scan = 1'b0;
                d.done = 1'b1;
                d.term = byte_i;
            end else if (kind == K_BAD || at_limit) begin
                d.scan = 1'b0;
                d.done = 1'b1;
                d.err  = 1'b1;
                d.term = byte_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scanning    = q.scan;
    assign done_o      = q.done;
    assign err_o       = q.err;
    assign term_byte_o = q.term;
    assign addr_ovr_o  = q.addr;
    assign opnd_ovr_o  = q.opnd;
    assign seg_o       = q.seg;
    assign count_o     = q.cnt;

endmodule

// File: rtl/fpesc_prefix_scan_sva.sv
module fpesc_prefix_scan_sva #(
    parameter int MAX_LEN = 15,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             byte_valid_i,
    input logic [7:0]       byte_i,
    input logic             done_o,
    input logic             err_o,
    input logic             addr_ovr_o,
    input logic             opnd_ovr_o,
    input logic [2:0]       seg_o,
    input logic [CNT_W-1:0] count_o,
    input logic             scanning
);

    logic accept;
    assign accept = scanning && byte_valid_i && !start_i;

    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (count_o == '0) && !addr_ovr_o && !opnd_ovr_o
                    && (seg_o == 3'd0) && !err_o);

    a_r5_rep_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (byte_i == 8'hF3 || byte_i == 8'hF2)
         && count_o != CNT_W'(MAX_LEN - 1))
        |=> $stable(addr_ovr_o) && $stable(opnd_ovr_o) && $stable(seg_o) && !done_o);

    a_r7_escape_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && byte_i[7:3] == 5'b11011) |=> done_o && !err_o);

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> count_o == $past(count_o) + 1'b1);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!scanning && !start_i)
        |=> $stable(count_o) && $stable(addr_ovr_o) && $stable(opnd_ovr_o)
            && $stable(seg_o) && !done_o);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind fpesc_prefix_scan fpesc_prefix_scan_sva #(.MAX_LEN(MAX_LEN)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .done_o       (done_o),
    .err_o        (err_o),
    .addr_ovr_o   (addr_ovr_o),
    .opnd_ovr_o   (opnd_ovr_o),
    .seg_o        (seg_o),
    .count_o      (count_o),
    .scanning     (scanning)
);

// File: tb/fpesc_prefix_scan_test.sv
`timescale 1ns/1ps
module fpesc_prefix_scan_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       done_o, err_o, addr_ovr_o, opnd_ovr_o;
    logic [7:0] term_byte_o;
    logic [2:0] seg_o;
    logic [3:0] count_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fpesc_prefix_scan uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .done_o       (done_o),
        .err_o        (err_o),
        .term_byte_o  (term_byte_o),
        .addr_ovr_o   (addr_ovr_o),
        .opnd_ovr_o   (opnd_ovr_o),
        .seg_o        (seg_o),
        .count_o      (count_o)
    );

    // {bytes (first byte lowest), length, err, term, addr, opnd, seg, count}
    localparam int NV = 12;
    localparam logic [69:0] VECS [NV] = '{
        {48'h0000000000D9, 4'd1, 1'b0, 8'hD9, 1'b0, 1'b0, 3'd0, 4'd1},
        {48'h00000000DC67, 4'd2, 1'b0, 8'hDC, 1'b1, 1'b0, 3'd0, 4'd2},
        {48'h000000009B66, 4'd2, 1'b0, 8'h9B, 1'b0, 1'b1, 3'd0, 4'd2},
        {48'h000000DF362E, 4'd3, 1'b0, 8'hDF, 1'b0, 1'b0, 3'd3, 4'd3},
        {48'h00D83E656426, 4'd5, 1'b0, 8'hD8, 1'b0, 1'b0, 3'd4, 4'd5},
        {48'h000000DDF2F3, 4'd3, 1'b0, 8'hDD, 1'b0, 1'b0, 3'd0, 4'd3},
        {48'h00000000F066, 4'd2, 1'b1, 8'hF0, 1'b0, 1'b1, 3'd0, 4'd2},
        {48'h000000009067, 4'd2, 1'b1, 8'h90, 1'b1, 1'b0, 3'd0, 4'd2},
        {48'h0000DB676664, 4'd4, 1'b0, 8'hDB, 1'b1, 1'b1, 3'd5, 4'd4},
        {48'h00000000C865, 4'd2, 1'b1, 8'hC8, 1'b0, 1'b0, 3'd6, 4'd2},
        {48'h0000000000D7, 4'd1, 1'b1, 8'hD7, 1'b0, 1'b0, 3'd0, 4'd1},
        {48'h0000000000E0, 4'd1, 1'b1, 8'hE0, 1'b0, 1'b0, 3'd0, 4'd1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b);
        byte_valid_i = 1'b1;
        byte_i = b;
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset done", done_o, 0);
        check("R1 reset err", err_o, 0);
        check("R1 reset count", count_o, 0);
        check("R1 reset seg", seg_o, 0);

        // R1 bytes with no armed scan are ignored
        feed(8'h67);
        check("R1 idle addr", addr_ovr_o, 0);
        check("R1 idle count", count_o, 0);
        check("R1 idle done", done_o, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [69:0] v;
            v = VECS[i];
            pulse_start();
            for (int k = 0; k < int'(v[21:18]); k++) feed(v[22 + k*8 +: 8]);
            check("R6 vector done", done_o, 1);
            check("R8 vector err", err_o, v[17]);
            check("R7 vector term", term_byte_o, v[16:9]);
            check("R2 vector addr", addr_ovr_o, v[8]);
            check("R3 vector opnd", opnd_ovr_o, v[7]);
            check("R4 vector seg", seg_o, v[6:4]);
            check("R9 vector count", count_o, v[3:0]);
            @(negedge clk);
            check("R11 done drops", done_o, 0);
        end

        // R10: after the last scan ended (error, seg 0, count 1), bytes are ignored
        feed(8'h66);
        feed(8'hD9);
        check("R10 opnd held", opnd_ovr_o, 0);
        check("R10 count held", count_o, 1);
        check("R10 term held", term_byte_o, 8'hE0);
        check("R10 no done", done_o, 0);

        // R1: start clears collected overrides
        pulse_start();
        feed(8'h67);
        feed(8'h65);
        pulse_start();
        check("R1 clear addr", addr_ovr_o, 0);
        check("R1 clear seg", seg_o, 0);
        check("R1 clear count", count_o, 0);

        // R1: byte offered in the start cycle is dropped
        @(negedge clk);
        start_i = 1'b1;
        byte_valid_i = 1'b1;
        byte_i = 8'h67;
        @(negedge clk);
        start_i = 1'b0;
        byte_valid_i = 1'b0;
        check("R1 start-cycle addr", addr_ovr_o, 0);
        check("R1 start-cycle count", count_o, 0);
        feed(8'hD9);
        check("R1 start-cycle end count", count_o, 1);

        // R9: terminator as byte 15 succeeds
        pulse_start();
        for (int k = 0; k < 14; k++) feed(8'hF3);
        check("R5 rep no done", done_o, 0);
        feed(8'hD9);
        check("R9 limit ok done", done_o, 1);
        check("R9 limit ok err", err_o, 0);
        check("R9 limit ok count", count_o, 15);
        check("R5 rep no addr", addr_ovr_o, 0);

        // R9: prefix as byte 15 ends in error
        pulse_start();
        for (int k = 0; k < 15; k++) feed(8'hF2);
        check("R9 limit err done", done_o, 1);
        check("R9 limit err flag", err_o, 1);
        check("R9 limit err term", term_byte_o, 8'hF2);
        check("R9 limit err count", count_o, 15);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule